// File: doc/BRIEF.md
# Bidirectional Double-Data-Rate Pad Register Cell

This cell sits between the core and one bidirectional pin group. Every clock period it moves two words in each direction. On the way out it launches a high-phase word and a low-phase word for the pad data. It also launches a high-phase and a low-phase value for the pad driver enable. On the way in it samples the pad on both clock edges and hands the core both words together, aligned to the rising edge. Each direction uses one register clocked on the rising edge and one clocked on the falling edge. The six edge registers form three pairs: input, output data and output enable. A rising-edge realignment stage follows the input pair.

A build parameter selects input-only, output-only or bidirectional operation. Another parameter sets the power-up level of every register, either all ones or all zeros. That level also decides what the single asynchronous control line does. With a low power-up level the line clears the registers. With a high power-up level it presets them. There is no separate reset input per register. A synchronous reset and a clock enable complete the control set. The pad itself is modelled as three separate signals: the driven value, the enable and the received value.

Top module: `ddrio_cell`

## Requirements
- R1: While the clock is high, `pad_o` shows the `d_out_hi` word that was taken at the most recent rising edge at which `ce` was 1 and `srst` was 0.
- R2: While the clock is low, `pad_o` shows the `d_out_lo` word that was taken at the most recent falling edge at which `ce` was 1 and `srst` was 0.
- R3: In bidirectional mode, `pad_oe` follows `oe_hi` during the high phase and `oe_lo` during the low phase, with the same edge and enable rules as the data. Here 1 means the pad is driven.
- R4: `pad_i` is sampled at a rising edge and at the falling edge that follows it. At the next rising edge both samples appear together: the rising sample on `q_in_hi` and the falling sample on `q_in_lo`. Sampling happens whatever the value of `pad_oe`.
- R5: At an edge where `ce` is 0 and `srst` is 0, no register changes, so `pad_o`, `pad_oe`, `q_in_hi` and `q_in_lo` hold their values.
- R6: At an edge where `srst` is 1, every register clocked on that edge loads the power-up level, whatever the value of `ce`.
- R7: While `async_ctl` is 1, every register is at the power-up level at once, regardless of the clock and `ce`. The level is all ones when `INIT_HIGH` is 1 (preset) and all zeros when it is 0 (clear).
- R8: With `MODE` set to input-only, `pad_o` and `pad_oe` are 0 and the input path behaves as in R4. With `MODE` set to output-only, `pad_oe` is 1, `q_in_hi` and `q_in_lo` are 0, and the output path behaves as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| ce | input | 1 | Clock enable for every register |
| srst | input | 1 | Synchronous reset to the power-up level; has priority over `ce` |
| async_ctl | input | 1 | Shared asynchronous preset or clear, active high |
| d_out_hi | input | W | Word driven to the pad in the high clock phase |
| d_out_lo | input | W | Word driven to the pad in the low clock phase |
| oe_hi | input | 1 | Pad enable for the high clock phase |
| oe_lo | input | 1 | Pad enable for the low clock phase |
| pad_o | output | W | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |
| pad_i | input | W | Value received from the pad |
| q_in_hi | output | W | Rising-edge sample, realigned to the rising edge |
| q_in_lo | output | W | Falling-edge sample, realigned to the rising edge |

## Verification
A rising-edge launch is due on `pad_o` and `pad_oe` during the high phase that starts at that same edge. A falling-edge launch is due during the low phase that starts at that edge. An input pair is due one full period after its rising sample, which is half a period after its falling sample. The bench keeps a behavioural model that it updates at each edge. It compares the outputs half a nanosecond into each phase, and it drives inputs one nanosecond after an edge, so every stimulus settles well before the edge that consumes it. The asynchronous line is checked half a nanosecond after it rises, between edges, so that no clock edge could be the cause of the forced level.

// File: rtl/ddrio_pkg.sv
`timescale 1ns/1ps
package ddrio_pkg;

   typedef enum logic [1:0] {
      DDRIO_IN    = 2'd0,
      DDRIO_OUT   = 2'd1,
      DDRIO_BIDIR = 2'd2
   } ddrio_mode_e;

   function automatic bit ddrio_has_in(ddrio_mode_e m);
      return (m == DDRIO_IN) || (m == DDRIO_BIDIR);
   endfunction

   function automatic bit ddrio_has_out(ddrio_mode_e m);
      return (m == DDRIO_OUT) || (m == DDRIO_BIDIR);
   endfunction

endpackage

// File: rtl/ddrio_edge_reg.sv
`timescale 1ns/1ps
// One register bank clocked on a chosen clock edge. The shared asynchronous
// line forces the power-up level: it acts as a clear or a preset depending on
// INIT_HIGH.
module ddrio_edge_reg #(
   parameter int unsigned W         = 8,
   parameter bit          INIT_HIGH = 1'b0,
   parameter bit          FALLING   = 1'b0
) (
   input  logic         clk,
   input  logic         async_ctl,
   input  logic         srst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] LVL = INIT_HIGH ? {W{1'b1}} : {W{1'b0}};

   generate
      if (FALLING) begin : g_fall
         always_ff @(negedge clk or posedge async_ctl) begin
            if (async_ctl)  q <= LVL;
            else if (srst)  q <= LVL;
            else if (ce)    q <= d;
         end
      end else begin : g_rise
         always_ff @(posedge clk or posedge async_ctl) begin
            if (async_ctl)  q <= LVL;
            else if (srst)  q <= LVL;
            else if (ce)    q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/ddrio_ddr_launch.sv
`timescale 1ns/1ps
// Register pair that launches one value per clock phase; the clock level picks
// which register reaches the pad.
module ddrio_ddr_launch #(
   parameter int unsigned W         = 8,
   parameter bit          INIT_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         async_ctl,
   input  logic         srst,
   input  logic         ce,
   input  logic [W-1:0] d_rise,
   input  logic [W-1:0] d_fall,
   output logic [W-1:0] pad
);
   logic [W-1:0] q_rise;
   logic [W-1:0] q_fall;

   ddrio_edge_reg #(.W(W), .INIT_HIGH(INIT_HIGH), .FALLING(1'b0)) u_rise (
      .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
      .d(d_rise), .q(q_rise)
   );

   ddrio_edge_reg #(.W(W), .INIT_HIGH(INIT_HIGH), .FALLING(1'b1)) u_fall (
      .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
      .d(d_fall), .q(q_fall)
   );

   assign pad = clk ? q_rise : q_fall;
endmodule

// File: rtl/ddrio_ddr_capture.sv
`timescale 1ns/1ps
// Samples the pad on both edges, then moves both samples together onto the
// rising edge for the core.
module ddrio_ddr_capture #(
   parameter int unsigned W         = 8,
   parameter bit          INIT_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         async_ctl,
   input  logic         srst,
   input  logic         ce,
   input  logic [W-1:0] pad,
   output logic [W-1:0] q_hi,
   output logic [W-1:0] q_lo
);
   localparam int unsigned W2 = 2 * W;

   logic [W-1:0]  cap_rise;
   logic [W-1:0]  cap_fall;
   logic [W2-1:0] aligned;

   ddrio_edge_reg #(.W(W), .INIT_HIGH(INIT_HIGH), .FALLING(1'b0)) u_cap_rise (
      .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
      .d(pad), .q(cap_rise)
   );

   ddrio_edge_reg #(.W(W), .INIT_HIGH(INIT_HIGH), .FALLING(1'b1)) u_cap_fall (
      .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
      .d(pad), .q(cap_fall)
   );

   ddrio_edge_reg #(.W(W2), .INIT_HIGH(INIT_HIGH), .FALLING(1'b0)) u_align (
      .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
      .d({cap_rise, cap_fall}), .q(aligned)
   );

   assign q_hi = aligned[W2-1:W];
   assign q_lo = aligned[W-1:0];
endmodule

// File: rtl/ddrio_cell.sv
`timescale 1ns/1ps
module ddrio_cell
   import ddrio_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter ddrio_mode_e MODE      = DDRIO_BIDIR,
   parameter bit          INIT_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         ce,
   input  logic         srst,
   input  logic         async_ctl,
   input  logic [W-1:0] d_out_hi,
   input  logic [W-1:0] d_out_lo,
   input  logic         oe_hi,
   input  logic         oe_lo,
   output logic [W-1:0] pad_o,
   output logic         pad_oe,
   input  logic [W-1:0] pad_i,
   output logic [W-1:0] q_in_hi,
   output logic [W-1:0] q_in_lo
);
   localparam bit HAS_IN  = ddrio_has_in(MODE);
   localparam bit HAS_OUT = ddrio_has_out(MODE);

   generate
      if (W < 1) begin : g_bad_width
         $error("ddrio_cell: W must be at least 1");
      end
      if (!HAS_IN && !HAS_OUT) begin : g_bad_mode
         $error("ddrio_cell: MODE selects no path");
      end

      if (HAS_IN) begin : g_in
         ddrio_ddr_capture #(.W(W), .INIT_HIGH(INIT_HIGH)) u_cap (
            .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
            .pad(pad_i), .q_hi(q_in_hi), .q_lo(q_in_lo)
         );
      end else begin : g_no_in
         assign q_in_hi = '0;
         assign q_in_lo = '0;
      end

      if (HAS_OUT) begin : g_out
         ddrio_ddr_launch #(.W(W), .INIT_HIGH(INIT_HIGH)) u_dat (
            .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
            .d_rise(d_out_hi), .d_fall(d_out_lo), .pad(pad_o)
         );
         if (MODE == DDRIO_BIDIR) begin : g_oe
            ddrio_ddr_launch #(.W(1), .INIT_HIGH(INIT_HIGH)) u_oe (
               .clk(clk), .async_ctl(async_ctl), .srst(srst), .ce(ce),
               .d_rise(oe_hi), .d_fall(oe_lo), .pad(pad_oe)
            );
         end else begin : g_oe_fixed
            assign pad_oe = 1'b1;
         end
      end else begin : g_no_out
         assign pad_o  = '0;
         assign pad_oe = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ddrio_cell_chk.sv
`timescale 1ns/1ps
module ddrio_cell_chk
   import ddrio_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter ddrio_mode_e MODE      = DDRIO_BIDIR,
   parameter bit          INIT_HIGH = 1'b0
) (
   input logic         clk,
   input logic         ce,
   input logic         srst,
   input logic         async_ctl,
   input logic [W-1:0] d_out_hi,
   input logic [W-1:0] d_out_lo,
   input logic         oe_hi,
   input logic         oe_lo,
   input logic [W-1:0] pad_o,
   input logic         pad_oe,
   input logic [W-1:0] q_in_hi,
   input logic [W-1:0] q_in_lo
);
   localparam logic [W-1:0] LVL = INIT_HIGH ? {W{1'b1}} : {W{1'b0}};

   // Inputs seen at the last edge of each kind, plus whether that edge loaded.
   logic [W-1:0] hi_seen, lo_seen;
   logic         oeh_seen, oel_seen, load_r, load_f;

   always_ff @(posedge clk or posedge async_ctl) begin
      if (async_ctl) begin
         load_r <= 1'b0; hi_seen <= '0; oeh_seen <= 1'b0;
      end else begin
         load_r <= ce && !srst; hi_seen <= d_out_hi; oeh_seen <= oe_hi;
      end
   end

   always_ff @(negedge clk or posedge async_ctl) begin
      if (async_ctl) begin
         load_f <= 1'b0; lo_seen <= '0; oel_seen <= 1'b0;
      end else begin
         load_f <= ce && !srst; lo_seen <= d_out_lo; oel_seen <= oe_lo;
      end
   end

   generate
      if (ddrio_has_out(MODE)) begin : g_out_chk
         AST_HIGH_PHASE_WORD: assert property (@(negedge clk) disable iff (async_ctl)
            load_r |-> pad_o == hi_seen); // R1
         AST_LOW_PHASE_WORD: assert property (@(posedge clk) disable iff (async_ctl)
            load_f |-> pad_o == lo_seen); // R2
         AST_ASYNC_OUT_LEVEL: assert property (@(posedge clk)
            (async_ctl && $past(async_ctl)) |-> pad_o == LVL); // R7
      end
      if (MODE == DDRIO_BIDIR) begin : g_oe_chk
         AST_OE_HIGH_PHASE: assert property (@(negedge clk) disable iff (async_ctl)
            load_r |-> pad_oe == oeh_seen); // R3
         AST_OE_LOW_PHASE: assert property (@(posedge clk) disable iff (async_ctl)
            load_f |-> pad_oe == oel_seen); // R3
      end
      if (ddrio_has_in(MODE)) begin : g_in_chk
         AST_CE_HOLDS_INPUT: assert property (@(posedge clk) disable iff (async_ctl)
            (!ce && !srst) |=> ($stable(q_in_hi) && $stable(q_in_lo))); // R5
         AST_SRST_INPUT_LEVEL: assert property (@(posedge clk) disable iff (async_ctl)
            srst |=> (q_in_hi == LVL && q_in_lo == LVL)); // R6
         AST_ASYNC_IN_LEVEL: assert property (@(posedge clk)
            (async_ctl && $past(async_ctl)) |-> (q_in_hi == LVL && q_in_lo == LVL)); // R7
      end
   endgenerate
endmodule

bind ddrio_cell ddrio_cell_chk #(.W(W), .MODE(MODE), .INIT_HIGH(INIT_HIGH)) chk_i (
   .clk(clk), .ce(ce), .srst(srst), .async_ctl(async_ctl),
   .d_out_hi(d_out_hi), .d_out_lo(d_out_lo), .oe_hi(oe_hi), .oe_lo(oe_lo),
   .pad_o(pad_o), .pad_oe(pad_oe), .q_in_hi(q_in_hi), .q_in_lo(q_in_lo)
);

// File: tb/ddrio_cell_tb_top.sv
`timescale 1ns/1ps
module ddrio_cell_tb_top;
   import ddrio_pkg::*;

   localparam int unsigned W       = 8;
   localparam bit          LVL_BIT = 1'b1;              // benches the preset variant
   localparam logic [W-1:0] LVL    = {W{LVL_BIT}};
   localparam int          NCYC    = 300;
   localparam int          ASYNC_K = 120;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;                              // 200 MHz

   logic         ce = 1'b0, srst = 1'b0, async_ctl = 1'b0;
   logic [W-1:0] d_out_hi = '0, d_out_lo = '0, pad_i = '0;
   logic         oe_hi = 1'b0, oe_lo = 1'b0;
   logic [W-1:0] pad_o, q_in_hi, q_in_lo;
   logic         pad_oe;
   logic [W-1:0] pad_o_in, q_hi_in, q_lo_in, pad_o_out, q_hi_out, q_lo_out;
   logic         pad_oe_in, pad_oe_out;

   ddrio_cell #(.W(W), .MODE(DDRIO_BIDIR), .INIT_HIGH(LVL_BIT)) dut_i (
      .clk(clk), .ce(ce), .srst(srst), .async_ctl(async_ctl),
      .d_out_hi(d_out_hi), .d_out_lo(d_out_lo), .oe_hi(oe_hi), .oe_lo(oe_lo),
      .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i),
      .q_in_hi(q_in_hi), .q_in_lo(q_in_lo));

   ddrio_cell #(.W(W), .MODE(DDRIO_IN), .INIT_HIGH(LVL_BIT)) dut_in_i (
      .clk(clk), .ce(ce), .srst(srst), .async_ctl(async_ctl),
      .d_out_hi(d_out_hi), .d_out_lo(d_out_lo), .oe_hi(oe_hi), .oe_lo(oe_lo),
      .pad_o(pad_o_in), .pad_oe(pad_oe_in), .pad_i(pad_i),
      .q_in_hi(q_hi_in), .q_in_lo(q_lo_in));

   ddrio_cell #(.W(W), .MODE(DDRIO_OUT), .INIT_HIGH(LVL_BIT)) dut_out_i (
      .clk(clk), .ce(ce), .srst(srst), .async_ctl(async_ctl),
      .d_out_hi(d_out_hi), .d_out_lo(d_out_lo), .oe_hi(oe_hi), .oe_lo(oe_lo),
      .pad_o(pad_o_out), .pad_oe(pad_oe_out), .pad_i(pad_i),
      .q_in_hi(q_hi_out), .q_in_lo(q_lo_out));

   int  n_vec = 0, n_bad = 0;
   bit  done  = 1'b0;

   // Reference state: what each output should present.
   logic [W-1:0] m_out_r, m_out_f, m_cap_r, m_cap_f, m_q_hi, m_q_lo;
   logic         m_oe_r, m_oe_f;
   // Stimulus for the current cycle.
   logic [W-1:0] s_hi, s_lo, s_phi, s_plo;
   logic         s_oh, s_ol, s_ce, s_srst;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   task automatic model_all_level();
      m_out_r = LVL; m_out_f = LVL; m_cap_r = LVL; m_cap_f = LVL;
      m_q_hi  = LVL; m_q_lo  = LVL; m_oe_r  = LVL_BIT; m_oe_f = LVL_BIT;
   endtask

   task automatic make_stim(input int k);
      s_hi  = W'($urandom); s_lo  = W'($urandom);
      s_phi = W'($urandom); s_plo = W'($urandom);
      s_oh  = 1'($urandom); s_ol  = 1'($urandom);
      if (k < 40)       s_ce = 1'b1;
      else if (k < 60)  s_ce = 1'($urandom);
      else if (k < 70)  s_ce = (k % 2 == 0);
      else              s_ce = ($urandom % 4 != 0);
      if (k >= 60 && k < 70) s_srst = (k % 3 == 0);   // R6: some with ce=1, some with ce=0
      else if (k >= 70)      s_srst = ($urandom % 16 == 0);
      else                   s_srst = 1'b0;
      ce = s_ce; srst = s_srst; d_out_hi = s_hi; d_out_lo = s_lo;
      oe_hi = s_oh; oe_lo = s_ol; pad_i = s_phi;
   endtask

   task automatic check_high_phase(input string tag);
      check({tag, " R1 pad_o high phase"}, pad_o, m_out_r);
      check({tag, " R3 pad_oe high phase"}, W'(pad_oe), W'(m_oe_r));
      check({tag, " R4 q_in_hi"}, q_in_hi, m_q_hi);
      check({tag, " R4 q_in_lo"}, q_in_lo, m_q_lo);
      check({tag, " R8 in-only q_in_hi"}, q_hi_in, m_q_hi);
      check({tag, " R8 in-only q_in_lo"}, q_lo_in, m_q_lo);
      check({tag, " R8 in-only pad_o"}, pad_o_in, '0);
      check({tag, " R8 in-only pad_oe"}, W'(pad_oe_in), '0);
      check({tag, " R8 out-only pad_o"}, pad_o_out, m_out_r);
      check({tag, " R8 out-only pad_oe"}, W'(pad_oe_out), W'(1));
      check({tag, " R8 out-only q_in"}, q_hi_out | q_lo_out, '0);
   endtask

   task automatic check_low_phase(input string tag);
      check({tag, " R2 pad_o low phase"}, pad_o, m_out_f);
      check({tag, " R3 pad_oe low phase"}, W'(pad_oe), W'(m_oe_f));
      check({tag, " R8 out-only pad_o low"}, pad_o_out, m_out_f);
   endtask

   initial begin
      #1.0 async_ctl = 1'b1;
      model_all_level();
      #0.5 check_low_phase("R7 reset");              // clock still low, no edge yet
      check("R7 reset q_in_hi", q_in_hi, LVL);
      @(posedge clk); #0.5 check_high_phase("R7 reset held");
      @(negedge clk); #1.0 async_ctl = 1'b0;
      make_stim(0);
      for (int k = 0; k < NCYC; k++) begin
         @(posedge clk);
         if (s_srst) begin
            m_q_hi = LVL; m_q_lo = LVL; m_cap_r = LVL; m_out_r = LVL; m_oe_r = LVL_BIT;
         end else if (s_ce) begin
            m_q_hi = m_cap_r; m_q_lo = m_cap_f; m_cap_r = s_phi;
            m_out_r = s_hi; m_oe_r = s_oh;
         end
         #0.5 check_high_phase(s_srst ? "R6 srst" : (s_ce ? "R1/R4 run" : "R5 hold"));
         #0.5 pad_i = s_plo;
         if (k == ASYNC_K) begin
            async_ctl = 1'b1;
            #0.5 model_all_level();
            check_high_phase("R7 async mid-phase");
            @(negedge clk);
            #0.5 check_low_phase("R7 async held");
            #0.3 async_ctl = 1'b0;
            #0.2 make_stim(k + 1);
         end else begin
            @(negedge clk);
            if (s_srst) begin
               m_cap_f = LVL; m_out_f = LVL; m_oe_f = LVL_BIT;
            end else if (s_ce) begin
               m_cap_f = s_plo; m_out_f = s_lo; m_oe_f = s_ol;
            end
            #0.5 check_low_phase(s_srst ? "R6 srst" : (s_ce ? "R2 run" : "R5 hold"));
            #0.5 make_stim(k + 1);
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule